// File: doc/BRIEF.md
# Management Frame Port

A small network management port with no DMA engine. A host moves every frame through 32-bit register accesses. To transmit, the host writes a frame into a transmit buffer one word at a time. It then writes the byte length together with a go flag to the transmit control word. The block hands the frame to a MAC as a byte stream and clears the go flag when the last byte has been accepted.

To receive, the block captures one frame from the MAC byte stream. It reports the length, the error flags and a ready flag in the receive control word. The host drains the frame through a receive buffer port and then releases it. Only one frame exists in each direction at any time. A frame that arrives while the previous one is still held is discarded and counted.

Two interrupt causes are available, and each has its own enable bit: a frame is ready to read, and a transmission has finished. All register values cross the bus with reversed byte lanes, which is big-endian presentation.

Top module: `mgmt_frame_port`

## Requirements
- R1: After reset, the transmit control, receive control and interrupt enable registers read 0, `irq` is 0, `mac_tx_valid` is 0 and `rx_drop_count` is 0.
- R2: Writing transmit control (offset 0x800) with bit 15 set and the length in bits 10:0 sends exactly that many bytes from the words written at offset 0x808. The bytes leave in word order, and within each word they leave from byte lane 31:24 down to 7:0. `mac_tx_last` marks the final byte, and data is held stable while `mac_tx_ready` is low.
- R3: Transmit control bit 15 reads 1 from the launch until the last byte is accepted and 0 afterwards. The length stays readable, and bit 14 reads 1 if `mac_tx_err` was high when any byte was accepted. Writing 0 acknowledges and clears the register.
- R4: A received frame sets receive control (offset 0x810) bit 15 and places the byte count in bits 10:0. Reads at offset 0x818 return the frame as ceil(length/4) words. The first byte sits in lanes 31:24, and the valid bytes of a short last word occupy the most significant lanes.
- R5: Receive control bit 14 reports that `mac_rx_err` was seen during the frame, and bit 13 reports `mac_rx_crc_err` on the last byte. The frame is still stored and readable when either flag is set.
- R6: A read at offset 0x818 after all words of the held frame have been read returns 0 and does not move the read position. Any write to receive control releases the frame, and the register then reads 0.
- R7: A frame whose first byte arrives while a frame is held is dropped whole, and `rx_drop_count` increases by one at its last byte. The held frame is unchanged.
- R8: `irq` is high when enable bit 0 (offset 0x8C0) is set and a received frame is held, or when enable bit 1 is set and a finished transmission has not been acknowledged. A completion that happens while bit 1 is clear still raises `irq` once bit 1 is set.
- R9: On the bus, register byte lanes are reversed. A held 5-byte frame with no errors makes receive control read 32'h05800000 on `h_rdata`.
- R10: Writes to transmit control or to the transmit buffer while a frame is in flight have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | 1 for write, 0 for read |
| h_addr | input | ADDR_W | Byte address of the register |
| h_wdata | input | 32 | Write data, big-endian lanes |
| h_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Combined interrupt request |
| mac_tx_valid | output | 1 | Transmit byte available |
| mac_tx_data | output | 8 | Transmit byte |
| mac_tx_last | output | 1 | Final byte of the frame |
| mac_tx_ready | input | 1 | MAC accepts the byte |
| mac_tx_err | input | 1 | MAC reports a transmit fault |
| mac_rx_valid | input | 1 | Received byte present |
| mac_rx_data | input | 8 | Received byte |
| mac_rx_last | input | 1 | Final byte of the received frame |
| mac_rx_err | input | 1 | Receive fault on this byte |
| mac_rx_crc_err | input | 1 | Checksum fault, given with the last byte |
| rx_drop_count | output | DROP_W | Saturating count of dropped frames |

## Verification
The hardest situations to reach are the overlaps between independent sides. These are a second frame arriving while the first is still held, a host write that hits transmit control while the MAC stalls in mid-frame, and a completion that lands while its interrupt is masked. The bench creates each overlap on purpose. It stalls `mac_tx_ready` before writing a competing launch, it streams a second frame before releasing the first, and it unmasks the transmit interrupt only after polling shows the frame has finished. Random lengths, including lengths that are not a multiple of four, and random ready stalls then cover the ordinary paths.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
   localparam int LEN_W = 11;

   localparam logic [11:0] OFF_TX_CTL = 12'h800;
   localparam logic [11:0] OFF_TX_BUF = 12'h808;
   localparam logic [11:0] OFF_RX_CTL = 12'h810;
   localparam logic [11:0] OFF_RX_BUF = 12'h818;
   localparam logic [11:0] OFF_IRQ_EN = 12'h8C0;

   localparam int BIT_GO    = 15;
   localparam int BIT_FAULT = 14;
   localparam int BIT_CRC   = 13;

   typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_mode_e;

   function automatic logic [31:0] lane_swap(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [7:0] pick_lane(input logic [31:0] w, input logic [1:0] idx);
      case (idx)
         2'd0:    return w[31:24];
         2'd1:    return w[23:16];
         2'd2:    return w[15:8];
         default: return w[7:0];
      endcase
   endfunction
endpackage

// File: rtl/mgp_word_ram.sv
module mgp_word_ram #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/mgp_tx_engine.sv
module mgp_tx_engine
   import mgp_pkg::*;
#(
   parameter int DEPTH_WORDS = 512,
   localparam int PTR_W      = $clog2(DEPTH_WORDS)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        buf_we,
   input  logic [31:0] buf_wdata,
   input  logic        ctl_we,
   input  logic [31:0] ctl_wdata,
   input  logic        mac_ready,
   input  logic        mac_err,
   output logic        mac_valid,
   output logic [7:0]  mac_data,
   output logic        mac_last,
   output logic [31:0] ctl_rdata,
   output logic        done_flag
);
   logic             busy_q, fault_q, done_q;
   logic [LEN_W-1:0] len_q, bidx_q;
   logic [PTR_W-1:0] wptr_q;
   logic [31:0]      rd_word;
   logic             go, ack, fill, xfer, at_end, len_zero;
   logic [PTR_W-1:0] raddr;

   // host side: launch/ack only while idle, buffer frozen in flight
   assign go       = ctl_we && !busy_q &&  ctl_wdata[BIT_GO];
   assign ack      = ctl_we && !busy_q && !ctl_wdata[BIT_GO];
   assign fill     = buf_we && !busy_q;
   assign len_zero = (ctl_wdata[LEN_W-1:0] == '0);
   assign at_end   = (bidx_q == len_q - 1'b1);
   assign xfer     = busy_q && mac_ready;
   assign raddr    = PTR_W'(bidx_q >> 2);

   mgp_word_ram #(.DEPTH(DEPTH_WORDS), .WIDTH(32)) u_ram (
      .clk   (clk),
      .we    (fill),
      .waddr (wptr_q),
      .wdata (buf_wdata),
      .raddr (raddr),
      .rdata (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         fault_q <= 1'b0;
         done_q  <= 1'b0;
         len_q   <= '0;
         bidx_q  <= '0;
         wptr_q  <= '0;
      end else begin
         if (fill) wptr_q <= wptr_q + 1'b1;
         if (go) begin
            len_q   <= ctl_wdata[LEN_W-1:0];
            bidx_q  <= '0;
            fault_q <= 1'b0;
            wptr_q  <= '0;
            busy_q  <= !len_zero;
            done_q  <= len_zero;
         end else if (ack) begin
            len_q   <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
            wptr_q  <= '0;
         end else if (xfer) begin
            if (mac_err) fault_q <= 1'b1;
            if (at_end) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               bidx_q <= bidx_q + 1'b1;
            end
         end
      end
   end

   assign mac_valid = busy_q;
   assign mac_last  = busy_q && at_end;
   assign mac_data  = busy_q ? pick_lane(rd_word, bidx_q[1:0]) : 8'h00;
   assign ctl_rdata = {16'h0, busy_q, fault_q, 3'b000, len_q};
   assign done_flag = done_q;
endmodule

// File: rtl/mgp_rx_engine.sv
module mgp_rx_engine
   import mgp_pkg::*;
#(
   parameter int DEPTH_WORDS = 512,
   parameter int DROP_W      = 16,
   localparam int PTR_W      = $clog2(DEPTH_WORDS),
   localparam int CAP        = (DEPTH_WORDS * 4 > 2047) ? 2047 : DEPTH_WORDS * 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mac_valid,
   input  logic [7:0]        mac_data,
   input  logic              mac_last,
   input  logic              mac_err,
   input  logic              mac_crc_err,
   input  logic              ctl_we,
   input  logic              buf_pop,
   output logic [31:0]       ctl_rdata,
   output logic [31:0]       buf_rdata,
   output logic              ready,
   output logic [DROP_W-1:0] drop_cnt
);
   rx_mode_e          mode_q;
   logic [LEN_W:0]    cnt_q, k, wsum;
   logic [31:0]       acc_q, acc_n, ram_q;
   logic              ready_q, fault_q, crc_q, sticky_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-2:0]  rptr_q, words;
   logic [DROP_W-1:0] drop_q;
   logic              take, toss, fits, have, frame_fault;

   assign take = mac_valid && (mode_q == RX_FILL || (mode_q == RX_IDLE && !ready_q));
   assign toss = mac_valid && !take;
   assign k    = (mode_q == RX_FILL) ? cnt_q : '0;
   assign fits = (k < (LEN_W+1)'(CAP));
   assign frame_fault = ((mode_q == RX_FILL) && sticky_q) || mac_err || !fits;

   // pack the byte into its lane, most significant lane first
   always_comb begin
      acc_n = (k[1:0] == 2'd0) ? 32'h0 : acc_q;
      case (k[1:0])
         2'd0:    acc_n[31:24] = mac_data;
         2'd1:    acc_n[23:16] = mac_data;
         2'd2:    acc_n[15:8]  = mac_data;
         default: acc_n[7:0]   = mac_data;
      endcase
   end

   assign wsum  = {1'b0, len_q} + (LEN_W+1)'(3);
   assign words = wsum[LEN_W:2];
   assign have  = ready_q && (rptr_q < words);

   mgp_word_ram #(.DEPTH(DEPTH_WORDS), .WIDTH(32)) u_ram (
      .clk   (clk),
      .we    (take && fits),
      .waddr (PTR_W'(k >> 2)),
      .wdata (acc_n),
      .raddr (PTR_W'(rptr_q)),
      .rdata (ram_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= RX_IDLE;
         cnt_q    <= '0;
         acc_q    <= '0;
         ready_q  <= 1'b0;
         fault_q  <= 1'b0;
         crc_q    <= 1'b0;
         sticky_q <= 1'b0;
         len_q    <= '0;
         rptr_q   <= '0;
         drop_q   <= '0;
      end else begin
         if (take) begin
            acc_q <= acc_n;
            if (mac_last) begin
               ready_q  <= 1'b1;
               len_q    <= LEN_W'(k + 1'b1);
               fault_q  <= frame_fault;
               crc_q    <= mac_crc_err;
               mode_q   <= RX_IDLE;
               cnt_q    <= '0;
               sticky_q <= 1'b0;
               rptr_q   <= '0;
            end else begin
               mode_q   <= RX_FILL;
               cnt_q    <= k + 1'b1;
               sticky_q <= frame_fault;
            end
         end else if (toss) begin
            if (mac_last) begin
               mode_q <= RX_IDLE;
               if (drop_q != '1) drop_q <= drop_q + 1'b1;
            end else begin
               mode_q <= RX_DROP;
            end
         end
         if (ctl_we && ready_q) begin
            ready_q <= 1'b0;
            len_q   <= '0;
            fault_q <= 1'b0;
            crc_q   <= 1'b0;
            rptr_q  <= '0;
         end else if (buf_pop && have) begin
            rptr_q <= rptr_q + 1'b1;
         end
      end
   end

   assign buf_rdata = have ? ram_q : 32'h0;
   assign ctl_rdata = {16'h0, ready_q, fault_q, crc_q, 2'b00, len_q};
   assign ready     = ready_q;
   assign drop_cnt  = drop_q;
endmodule

// File: rtl/mgmt_frame_port.sv
module mgmt_frame_port
   import mgp_pkg::*;
#(
   parameter int DEPTH_WORDS    = 512,
   parameter int ADDR_W         = 12,
   parameter int DROP_W         = 16,
   parameter bit BUS_BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_sel,
   input  logic              h_wr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [31:0]       h_wdata,
   output logic [31:0]       h_rdata,
   output logic              irq,
   output logic              mac_tx_valid,
   output logic [7:0]        mac_tx_data,
   output logic              mac_tx_last,
   input  logic              mac_tx_ready,
   input  logic              mac_tx_err,
   input  logic              mac_rx_valid,
   input  logic [7:0]        mac_rx_data,
   input  logic              mac_rx_last,
   input  logic              mac_rx_err,
   input  logic              mac_rx_crc_err,
   output logic [DROP_W-1:0] rx_drop_count
);
   initial begin : p_cfg
      if (ADDR_W < 12) $fatal(1, "ADDR_W must cover the register offsets");
      if (DEPTH_WORDS < 2 || (DEPTH_WORDS & (DEPTH_WORDS - 1)) != 0)
         $fatal(1, "DEPTH_WORDS must be a power of two");
      if (DEPTH_WORDS > 512) $fatal(1, "DEPTH_WORDS beyond the 11-bit length field");
      if (DROP_W < 1) $fatal(1, "DROP_W must be positive");
   end

   logic [31:0] wr_val, rd_val, bus_rd;
   logic [31:0] tx_ctl_rd, rx_ctl_rd, rx_buf_rd;
   logic [1:0]  ien_q;
   logic        hit_txc, hit_txb, hit_rxc, hit_rxb, hit_ien;
   logic        tx_ctl_we, tx_buf_we, rx_ctl_we, rx_buf_re, ien_we, rd_en;
   logic        tx_done, rx_ready;

   generate
      if (BUS_BIG_ENDIAN) begin : g_swap
         assign wr_val = lane_swap(h_wdata);
         assign bus_rd = lane_swap(rd_val);
      end else begin : g_flat
         assign wr_val = h_wdata;
         assign bus_rd = rd_val;
      end
   endgenerate

   assign hit_txc = (h_addr == ADDR_W'(OFF_TX_CTL));
   assign hit_txb = (h_addr == ADDR_W'(OFF_TX_BUF));
   assign hit_rxc = (h_addr == ADDR_W'(OFF_RX_CTL));
   assign hit_rxb = (h_addr == ADDR_W'(OFF_RX_BUF));
   assign hit_ien = (h_addr == ADDR_W'(OFF_IRQ_EN));

   assign tx_ctl_we = h_sel && h_wr && hit_txc;
   assign tx_buf_we = h_sel && h_wr && hit_txb;
   assign rx_ctl_we = h_sel && h_wr && hit_rxc;
   assign ien_we    = h_sel && h_wr && hit_ien;
   assign rd_en     = h_sel && !h_wr;
   assign rx_buf_re = rd_en && hit_rxb;

   mgp_tx_engine #(.DEPTH_WORDS(DEPTH_WORDS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_we    (tx_buf_we),
      .buf_wdata (wr_val),
      .ctl_we    (tx_ctl_we),
      .ctl_wdata (wr_val),
      .mac_ready (mac_tx_ready),
      .mac_err   (mac_tx_err),
      .mac_valid (mac_tx_valid),
      .mac_data  (mac_tx_data),
      .mac_last  (mac_tx_last),
      .ctl_rdata (tx_ctl_rd),
      .done_flag (tx_done)
   );

   mgp_rx_engine #(.DEPTH_WORDS(DEPTH_WORDS), .DROP_W(DROP_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .mac_valid   (mac_rx_valid),
      .mac_data    (mac_rx_data),
      .mac_last    (mac_rx_last),
      .mac_err     (mac_rx_err),
      .mac_crc_err (mac_rx_crc_err),
      .ctl_we      (rx_ctl_we),
      .buf_pop     (rx_buf_re),
      .ctl_rdata   (rx_ctl_rd),
      .buf_rdata   (rx_buf_rd),
      .ready       (rx_ready),
      .drop_cnt    (rx_drop_count)
   );

   always_comb begin
      rd_val = 32'h0;
      if (hit_txc)      rd_val = tx_ctl_rd;
      else if (hit_rxc) rd_val = rx_ctl_rd;
      else if (hit_rxb) rd_val = rx_buf_rd;
      else if (hit_ien) rd_val = {30'h0, ien_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= 2'b00;
         h_rdata <= 32'h0;
      end else begin
         if (ien_we) ien_q <= wr_val[1:0];
         if (rd_en)  h_rdata <= bus_rd;
      end
   end

   assign irq = (ien_q[0] && rx_ready) || (ien_q[1] && tx_done);
endmodule

// File: rtl/mgp_checker.sv
module mgp_checker #(
   parameter int DROP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mac_tx_valid,
   input logic              mac_tx_ready,
   input logic [7:0]        mac_tx_data,
   input logic              mac_tx_last,
   input logic              irq,
   input logic [1:0]        ien,
   input logic              tx_done,
   input logic              tx_ctl_we,
   input logic              rx_ready,
   input logic              rx_rel,
   input logic [DROP_W-1:0] drop_cnt
);
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mac_tx_valid && !mac_tx_ready |=> mac_tx_valid && $stable(mac_tx_data) && $stable(mac_tx_last));

   a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      mac_tx_valid && mac_tx_ready && mac_tx_last |=> !mac_tx_valid);

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 2'b00) |-> !irq);

   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done && !tx_ctl_we |=> tx_done);

   a_r4_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && !rx_rel |=> rx_ready);

   a_r7_drop_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt >= $past(drop_cnt));
endmodule

bind mgmt_frame_port mgp_checker #(.DROP_W(DROP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mac_tx_valid (mac_tx_valid),
   .mac_tx_ready (mac_tx_ready),
   .mac_tx_data  (mac_tx_data),
   .mac_tx_last  (mac_tx_last),
   .irq          (irq),
   .ien          (ien_q),
   .tx_done      (tx_done),
   .tx_ctl_we    (tx_ctl_we),
   .rx_ready     (rx_ready),
   .rx_rel       (rx_ctl_we),
   .drop_cnt     (rx_drop_count)
);

// File: tb/tb_mgmt_frame_port.sv
module tb_mgmt_frame_port;
   import mgp_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        h_sel = 0, h_wr = 0;
   logic [11:0] h_addr = '0;
   logic [31:0] h_wdata = '0, h_rdata;
   logic        irq, mac_tx_valid, mac_tx_last;
   logic [7:0]  mac_tx_data;
   logic        mac_tx_ready = 0, mac_tx_err = 0;
   logic        mac_rx_valid = 0, mac_rx_last = 0, mac_rx_err = 0, mac_rx_crc_err = 0;
   logic [7:0]  mac_rx_data = '0;
   logic [15:0] rx_drop_count;

   int checks = 0, fails = 0;
   bit stall = 1'b0;
   logic [7:0] cap [0:2047];
   bit         cap_last [0:2047];
   int         cap_n = 0;

   mgmt_frame_port dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) mac_tx_ready = stall ? 1'b0 : (($urandom % 4) != 0);

   always @(posedge clk) begin
      if (mac_tx_valid && mac_tx_ready && cap_n < 2048) begin
         cap[cap_n] = mac_tx_data;
         cap_last[cap_n] = mac_tx_last;
         cap_n++;
      end
   end

   function automatic logic [7:0] gen(int f, int i);
      return 8'(f * 29 + i * 7 + 1);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [11:0] a, logic [31:0] v);
      @(negedge clk); h_sel = 1; h_wr = 1; h_addr = a; h_wdata = lane_swap(v);
      @(negedge clk); h_sel = 0; h_wr = 0;
   endtask

   task automatic bus_rd_raw(logic [11:0] a, output logic [31:0] v);
      @(negedge clk); h_sel = 1; h_wr = 0; h_addr = a;
      @(negedge clk); v = h_rdata; h_sel = 0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [31:0] v);
      logic [31:0] raw;
      bus_rd_raw(a, raw);
      v = lane_swap(raw);
   endtask

   task automatic tx_fill(int len, int fid);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] word;
         for (int j = 0; j < 4; j++)
            word[31-8*j -: 8] = (4*w + j < len) ? gen(fid, 4*w + j) : 8'hEE;
         bus_wr(OFF_TX_BUF, word);
      end
   endtask

   task automatic tx_wait(output logic [31:0] v);
      int guard = 0;
      do begin bus_rd(OFF_TX_CTL, v); guard++; end while (v[15] && guard < 5000);
   endtask

   task automatic tx_compare(string req, int len, int fid);
      int bad = 0;
      chk(req, cap_n, len);
      for (int i = 0; i < len && i < cap_n; i++)
         if (cap[i] !== gen(fid, i) || cap_last[i] !== (i == len - 1)) bad++;
      chk(req, bad, 0);
   endtask

   task automatic tx_frame(int len, bit inj, int fid);
      logic [31:0] v;
      tx_fill(len, fid);
      cap_n = 0;
      mac_tx_err = inj;
      bus_wr(OFF_TX_CTL, 32'h8000 | len);
      tx_wait(v);
      mac_tx_err = 0;
      tx_compare("R2 tx byte stream", len, fid);
      chk("R3 tx completion status", v, (inj ? 32'h4000 : 32'h0) | len);
      bus_wr(OFF_TX_CTL, 32'h0);
      bus_rd(OFF_TX_CTL, v);
      chk("R3 tx ack clears", v, 32'h0);
   endtask

   task automatic rx_send(int len, int fid, bit e, bit c);
      for (int i = 0; i < len; i++) begin
         if (($urandom % 3) == 0) begin
            @(negedge clk); mac_rx_valid = 0;
         end
         @(negedge clk);
         mac_rx_valid = 1; mac_rx_data = gen(fid, i);
         mac_rx_last = (i == len - 1);
         mac_rx_err = e && (i == len / 2);
         mac_rx_crc_err = c && (i == len - 1);
      end
      @(negedge clk);
      mac_rx_valid = 0; mac_rx_last = 0; mac_rx_err = 0; mac_rx_crc_err = 0;
   endtask

   task automatic rx_check(int len, int fid, bit e, bit c);
      logic [31:0] v;
      int bad = 0;
      bus_rd(OFF_RX_CTL, v);
      chk("R4/R5 rx status", v, 32'h8000 | (e ? 32'h4000 : 0) | (c ? 32'h2000 : 0) | len);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] exp, mask;
         exp = 0; mask = 0;
         for (int j = 0; j < 4; j++)
            if (4*w + j < len) begin
               exp[31-8*j -: 8] = gen(fid, 4*w + j);
               mask[31-8*j -: 8] = 8'hFF;
            end
         bus_rd(OFF_RX_BUF, v);
         if ((v & mask) !== exp) bad++;
      end
      chk("R4 rx words", bad, 0);
      bus_rd(OFF_RX_BUF, v);
      chk("R6 read past end", v, 32'h0);
      bus_rd(OFF_RX_BUF, v);
      chk("R6 read past end again", v, 32'h0);
      bus_wr(OFF_RX_CTL, 32'h0);
      bus_rd(OFF_RX_CTL, v);
      chk("R6 release clears", v, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [15:0] d0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 tx valid", mac_tx_valid, 0);
      chk("R1 drop count", rx_drop_count, 0);
      bus_rd(OFF_TX_CTL, v); chk("R1 tx ctl", v, 0);
      bus_rd(OFF_RX_CTL, v); chk("R1 rx ctl", v, 0);
      bus_rd(OFF_IRQ_EN, v); chk("R1 irq enable", v, 0);

      // R2/R3 directed lengths
      tx_frame(1, 0, 1);
      tx_frame(4, 0, 2);
      tx_frame(7, 1, 3);
      tx_frame(64, 0, 4);

      // R8 masked completion then unmask
      tx_fill(6, 5); cap_n = 0;
      bus_wr(OFF_TX_CTL, 32'h8006);
      tx_wait(v);
      chk("R8 masked tx no irq", irq, 0);
      bus_wr(OFF_IRQ_EN, 32'h2);
      chk("R8 unmask raises irq", irq, 1);
      bus_wr(OFF_TX_CTL, 32'h0);
      chk("R8 ack drops irq", irq, 0);

      // R10 writes during flight ignored
      stall = 1;
      tx_fill(8, 6); cap_n = 0;
      bus_wr(OFF_TX_CTL, 32'h8008);
      bus_wr(OFF_TX_CTL, 32'h8003);
      bus_wr(OFF_TX_BUF, 32'hDEADBEEF);
      bus_rd(OFF_TX_CTL, v);
      chk("R10 busy write ignored", v, 32'h8008);
      stall = 0;
      tx_wait(v);
      tx_compare("R10 frame intact", 8, 6);
      bus_wr(OFF_TX_CTL, 32'h0);
      bus_wr(OFF_IRQ_EN, 32'h0);

      // R4 rx basic, R9 raw bus view
      rx_send(5, 10, 0, 0);
      bus_rd_raw(OFF_RX_CTL, v);
      chk("R9 big-endian bus view", v, 32'h05800000);
      rx_check(5, 10, 0, 0);
      rx_send(64, 11, 0, 0);
      rx_check(64, 11, 0, 0);

      // R5 flags
      rx_send(13, 12, 1, 0); rx_check(13, 12, 1, 0);
      rx_send(9, 13, 0, 1);  rx_check(9, 13, 0, 1);

      // R8 rx interrupt
      rx_send(3, 14, 0, 0);
      chk("R8 rx masked no irq", irq, 0);
      bus_wr(OFF_IRQ_EN, 32'h1);
      chk("R8 rx irq", irq, 1);
      bus_wr(OFF_RX_CTL, 32'h0);
      chk("R8 rx release drops irq", irq, 0);
      bus_wr(OFF_IRQ_EN, 32'h0);

      // R7 drop while held
      d0 = rx_drop_count;
      rx_send(10, 15, 0, 0);
      rx_send(6, 16, 0, 0);
      chk("R7 drop counted", rx_drop_count, d0 + 1);
      rx_send(1, 17, 0, 0);
      chk("R7 single byte drop counted", rx_drop_count, d0 + 2);
      rx_check(10, 15, 0, 0);

      // random mix
      for (int it = 0; it < 20; it++) begin
         int tl, rl;
         bit te, re, rc;
         tl = 1 + ($urandom % 120); te = ($urandom % 4) == 0;
         rl = 1 + ($urandom % 120); re = ($urandom % 5) == 0; rc = ($urandom % 5) == 0;
         tx_frame(tl, te, 100 + it);
         rx_send(rl, 200 + it, re, rc);
         rx_check(rl, 200 + it, re, rc);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule